// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block is the core of an eight-level interrupt controller. It samples eight request lines and latches them into a request register. It keeps a register of the levels in service and raises an interrupt output when a pending level outranks everything in service. The CPU then sends a train of acknowledge pulses. For each pulse the block places one byte on an 8-bit data output.

The block supports two CPU styles, chosen by `cpu16_mode`:

- **Byte-wide CPU (`cpu16_mode` = 0):** three pulses. The first carries a subroutine-call opcode. The second carries the low byte of the call address. The third carries the high byte.
- **Word-wide CPU (`cpu16_mode` = 1):** two pulses. The first leaves the bus undriven. The second carries an 8-bit vector pointer.

In-service levels are retired in one of two ways. With automatic retirement, the level is cleared at the trailing edge of the last pulse. Otherwise a non-specific end-of-service strobe clears it. An acknowledge that finds nothing pending is answered as if level 7 had asked. This spurious case marks no level as in service.

Acknowledge pulses and request lines are asynchronous and pass through two-stage synchronizers. A pulse takes effect on its trailing edge in the clock domain. Priority is fixed: level 0 is the highest and level 7 the lowest.

Top module: `irq_vec_seq`

## Requirements
- R1: Requests and interrupt output. A high level on `irq_in[i]` is latched as pending level i. `int_out` rises within six clocks when the highest pending level (level 0 highest) outranks every in-service level, or when no level is in service.
- R2: No interrupt for lower levels. While a level is in service, a pending request of equal or lower priority does not raise `int_out`.
- R3: Opcode byte. With `cpu16_mode`=0, the first acknowledge pulse drives `data_out`=8'hCD with `data_oe`=1.
- R4: Low byte, spacing 4. With `cpu16_mode`=0 and `interval8`=0, the second pulse drives {`vec_top[4:2]`, level[2:0], 2'b00}.
- R5: Low byte, spacing 8. With `cpu16_mode`=0 and `interval8`=1, the second pulse drives {`vec_top[4:3]`, level[2:0], 3'b000}.
- R6: High byte. With `cpu16_mode`=0, the third pulse drives `vec_hi`.
- R7: Word-wide CPU. With `cpu16_mode`=1, the first pulse leaves `data_oe`=0. The second pulse drives {`vec_top[4:0]`, level[2:0]}.
- R8: Level selection. The trailing edge of the first pulse selects the highest pending level, marks it in service and removes it from the pending set. Once its line has dropped, the level raises no further interrupt.
- R9: Automatic retirement. With `auto_eoi`=1, the serviced level leaves service at the trailing edge of the last pulse (the third in byte mode, the second in word mode).
- R10: Strobe retirement. With `auto_eoi`=0, a level stays in service until `eoi_stb` is high for one clock. The strobe clears the highest-priority in-service level. It works in the same clock as a first-pulse selection.
- R11: Spurious acknowledge. If nothing is pending at the first trailing edge, the bytes are those of level 7 and no level is marked in service.
- R12: Interrupt gap. `int_out` holds its value through a sequence. It is low in the clock after the last pulse's trailing edge, then reasserts one clock later if a qualifying request is pending.
- R13: Bus idle. `data_oe` is low whenever no acknowledge pulse is present, and `data_out` is then 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Asynchronous request lines, bit 0 highest priority |
| ack_in | input | 1 | Asynchronous acknowledge pulse, active high |
| eoi_stb | input | 1 | One-clock non-specific end-of-service strobe |
| cpu16_mode | input | 1 | 1: two-pulse pointer sequence; 0: three-pulse call sequence |
| auto_eoi | input | 1 | 1: retire the level at the last pulse |
| interval8 | input | 1 | Call-address spacing: 0 = 4 bytes, 1 = 8 bytes |
| vec_top | input | 5 | Programmed upper bits of the low byte or pointer |
| vec_hi | input | 8 | Programmed high byte of the call address |
| int_out | output | 1 | Interrupt request to the CPU |
| data_out | output | 8 | Vector byte, 8'h00 when not driven |
| data_oe | output | 1 | Data drive enable |

## Verification
Two events can land in the same clock. The first pulse's trailing edge places a new level in service, and the end-of-service strobe retires the level that was already in service. The bench provokes this by raising the strobe in exactly the clock that registers the synchronized trailing edge, while an older, lower level is in service. It then checks the outcome at the ports only. A lower request stays blocked, because the new level is in service. After one more strobe that request is released, which shows that the strobe removed the older level and not the new one. The same coincidence analysis covers the last pulse meeting a newly arrived higher request, which is judged by the one-clock gap on the interrupt output.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int NLEV     = 8;
    localparam int LW       = $clog2(NLEV);
    localparam int BYTE_W   = 8;
    localparam int TOP_W    = BYTE_W - LW;
    localparam int SYNC_W   = NLEV + 1;
    localparam logic [BYTE_W-1:0] CALL_OPCODE = 8'hCD;
    localparam logic [LW-1:0]     FALLBACK_LVL = LW'(NLEV - 1);

    typedef enum logic [1:0] {
        ST_OPC = 2'd0,
        ST_LO  = 2'd1,
        ST_HI  = 2'd2
    } ack_step_e;

    typedef struct packed {
        logic          hit;
        logic [LW-1:0] idx;
    } prio_t;

    function automatic logic [NLEV-1:0] lvl_mask(input logic [LW-1:0] lvl);
        logic [NLEV-1:0] m;
        m = '0;
        m[lvl] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_vec_pkg::*;
(
    input  logic [NLEV-1:0] vec,
    output prio_t           res
);
    always_comb begin
        res = '0;
        for (int i = NLEV - 1; i >= 0; i--) begin
            if (vec[i]) begin
                res.hit = 1'b1;
                res.idx = LW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_lvl,
    input  logic              cpu16_mode,
    input  logic              interval8,
    input  logic [TOP_W-1:0]  vec_top,
    input  logic [BYTE_W-1:0] vec_hi,
    input  prio_t             pend,
    output ack_step_e         step,
    output logic              ack_fall,
    output logic              first_fire,
    output logic              last_fire,
    output logic [LW-1:0]     cur_lvl,
    output logic              cur_real,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe
);
    logic              ack_d;
    logic [BYTE_W-1:0] byte_sel;
    logic              drive;

    always_ff @(posedge clk) begin
        if (rst) ack_d <= 1'b0;
        else     ack_d <= ack_lvl;
    end

    assign ack_fall   = ack_d & ~ack_lvl;
    assign first_fire = ack_fall && (step == ST_OPC);
    assign last_fire  = ack_fall &&
                        ((cpu16_mode && step == ST_LO) || (!cpu16_mode && step == ST_HI));

    always_ff @(posedge clk) begin
        if (rst) begin
            step     <= ST_OPC;
            cur_lvl  <= '0;
            cur_real <= 1'b0;
        end else if (ack_fall) begin
            case (step)
                ST_OPC: begin
                    step     <= ST_LO;
                    cur_lvl  <= pend.hit ? pend.idx : FALLBACK_LVL;
                    cur_real <= pend.hit;
                end
                ST_LO:   step <= cpu16_mode ? ST_OPC : ST_HI;
                default: step <= ST_OPC;
            endcase
        end
    end

    always_comb begin
        byte_sel = '0;
        drive    = 1'b0;
        case (step)
            ST_OPC: begin
                byte_sel = CALL_OPCODE;
                drive    = !cpu16_mode;
            end
            ST_LO: begin
                drive = 1'b1;
                if (cpu16_mode)     byte_sel = {vec_top, cur_lvl};
                else if (interval8) byte_sel = {vec_top[TOP_W-1:TOP_W-2], cur_lvl, 3'b000};
                else                byte_sel = {vec_top[TOP_W-1:TOP_W-3], cur_lvl, 2'b00};
            end
            ST_HI: begin
                drive    = 1'b1;
                byte_sel = vec_hi;
            end
            default: begin
                drive    = 1'b0;
                byte_sel = '0;
            end
        endcase
    end

    assign data_oe  = ack_lvl & drive;
    assign data_out = data_oe ? byte_sel : '0;
endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq
    import irq_vec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  irq_in,
    input  logic        ack_in,
    input  logic        eoi_stb,
    input  logic        cpu16_mode,
    input  logic        auto_eoi,
    input  logic        interval8,
    input  logic [4:0]  vec_top,
    input  logic [7:0]  vec_hi,
    output logic        int_out,
    output logic [7:0]  data_out,
    output logic        data_oe
);
    logic [SYNC_W-1:0] sync_q;
    logic [NLEV-1:0]   irq_s;
    logic              ack_lvl;
    logic [NLEV-1:0]   irr;
    logic [NLEV-1:0]   isr;
    prio_t             irr_p;
    prio_t             isr_p;
    ack_step_e         step;
    logic              ack_fall;
    logic              first_fire;
    logic              last_fire;
    logic [LW-1:0]     cur_lvl;
    logic              cur_real;
    logic [NLEV-1:0]   take_mask;
    logic [NLEV-1:0]   eoi_mask;
    logic [NLEV-1:0]   aeoi_mask;
    logic              qualify;

    irq_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ack_in, irq_in}),
        .q   (sync_q)
    );

    assign irq_s   = sync_q[NLEV-1:0];
    assign ack_lvl = sync_q[NLEV];

    irq_prio_enc u_irr_enc (.vec(irr), .res(irr_p));
    irq_prio_enc u_isr_enc (.vec(isr), .res(isr_p));

    irq_ack_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ack_lvl    (ack_lvl),
        .cpu16_mode (cpu16_mode),
        .interval8  (interval8),
        .vec_top    (vec_top),
        .vec_hi     (vec_hi),
        .pend       (irr_p),
        .step       (step),
        .ack_fall   (ack_fall),
        .first_fire (first_fire),
        .last_fire  (last_fire),
        .cur_lvl    (cur_lvl),
        .cur_real   (cur_real),
        .data_out   (data_out),
        .data_oe    (data_oe)
    );

    assign take_mask = (first_fire && irr_p.hit) ? lvl_mask(irr_p.idx) : '0;
    assign eoi_mask  = (eoi_stb && isr_p.hit) ? lvl_mask(isr_p.idx) : '0;
    assign aeoi_mask = (last_fire && auto_eoi && cur_real) ? lvl_mask(cur_lvl) : '0;
    assign qualify   = irr_p.hit && (!isr_p.hit || (irr_p.idx < isr_p.idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            irr     <= '0;
            isr     <= '0;
            int_out <= 1'b0;
        end else begin
            irr <= (irr | irq_s) & ~take_mask;
            isr <= (isr & ~eoi_mask & ~aeoi_mask) | take_mask;
            if (last_fire)           int_out <= 1'b0;
            else if (step == ST_OPC) int_out <= qualify;
        end
    end
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk
    import irq_vec_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ack_lvl,
    input logic            ack_fall,
    input logic            last_fire,
    input logic            cur_real,
    input ack_step_e       step,
    input logic            cpu16_mode,
    input logic            auto_eoi,
    input logic            eoi_stb,
    input logic [NLEV-1:0] irr,
    input logic [NLEV-1:0] isr,
    input logic            int_out,
    input logic [7:0]      data_out,
    input logic            data_oe
);
    a_r3_call_code: assert property (@(posedge clk) disable iff (rst)
        (data_oe && !cpu16_mode && step == ST_OPC) |-> data_out == CALL_OPCODE);

    a_r7_quiet_first: assert property (@(posedge clk) disable iff (rst)
        (cpu16_mode && step == ST_OPC) |-> !data_oe);

    a_r13_oe_needs_ack: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> ack_lvl);

    a_r12_int_gap: assert property (@(posedge clk) disable iff (rst)
        last_fire |=> !int_out);

    a_r9_aeoi_retire: assert property (@(posedge clk) disable iff (rst)
        (last_fire && auto_eoi && cur_real && !eoi_stb)
            |=> $countones(isr) == $past($countones(isr)) - 1);

    a_r8_isr_taken: assert property (@(posedge clk) disable iff (rst)
        (ack_fall && step == ST_OPC && irr != '0) |=> isr != '0);

    a_r11_spurious_no_isr: assert property (@(posedge clk) disable iff (rst)
        (ack_fall && step == ST_OPC && irr == '0 && !eoi_stb) |=> $stable(isr));
endmodule

bind irq_vec_seq irq_vec_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack_lvl    (ack_lvl),
    .ack_fall   (ack_fall),
    .last_fire  (last_fire),
    .cur_real   (cur_real),
    .step       (step),
    .cpu16_mode (cpu16_mode),
    .auto_eoi   (auto_eoi),
    .eoi_stb    (eoi_stb),
    .irr        (irr),
    .isr        (isr),
    .int_out    (int_out),
    .data_out   (data_out),
    .data_oe    (data_oe)
);

// File: tb/sim_irq_vec_seq.sv
`timescale 1ns/1ps
module sim_irq_vec_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       ack_in = 1'b0;
    logic       eoi_stb = 1'b0;
    logic       cpu16_mode = 1'b0;
    logic       auto_eoi = 1'b1;
    logic       interval8 = 1'b0;
    logic [4:0] vec_top = 5'b10110;
    logic [7:0] vec_hi = 8'h3C;
    logic       int_out;
    logic [7:0] data_out;
    logic       data_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] pd [3];
    logic       po [3];
    logic       p_int;

    // table: {cpu16, interval8, level, expected low byte / pointer}
    localparam int NV = 7;
    localparam logic [12:0] VTAB [NV] = '{
        {1'b0, 1'b0, 3'd0, 8'hA0},
        {1'b0, 1'b0, 3'd3, 8'hAC},
        {1'b0, 1'b0, 3'd7, 8'hBC},
        {1'b0, 1'b1, 3'd2, 8'h90},
        {1'b0, 1'b1, 3'd6, 8'hB0},
        {1'b1, 1'b0, 3'd1, 8'hB1},
        {1'b1, 1'b1, 3'd4, 8'hB4}
    };

    always #4 clk = ~clk;

    irq_vec_seq u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ack_in(ack_in), .eoi_stb(eoi_stb),
        .cpu16_mode(cpu16_mode), .auto_eoi(auto_eoi), .interval8(interval8),
        .vec_top(vec_top), .vec_hi(vec_hi), .int_out(int_out),
        .data_out(data_out), .data_oe(data_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ack_pulse(input int k, input logic eoi_here);
        @(negedge clk) ack_in = 1'b1;
        repeat (4) @(negedge clk);
        pd[k] = data_out;
        po[k] = data_oe;
        ack_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        eoi_stb = eoi_here;
        @(negedge clk);
        eoi_stb = 1'b0;
        p_int = int_out;
    endtask

    task automatic run_seq(input logic eoi_first);
        ack_pulse(0, eoi_first);
        ack_pulse(1, 1'b0);
        if (!cpu16_mode) ack_pulse(2, 1'b0);
        repeat (2) @(negedge clk);
    endtask

    task automatic raise(input int lvl);
        @(negedge clk) irq_in[lvl] = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic drop_all();
        @(negedge clk) irq_in = '0;
    endtask

    task automatic eoi_pulse();
        @(negedge clk) eoi_stb = 1'b1;
        @(negedge clk) eoi_stb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R13 reset oe", {7'd0, data_oe}, 8'h00);
        chk("R13 reset data", data_out, 8'h00);
        chk("R1 reset int", {7'd0, int_out}, 8'h00);

        // vector table walk, automatic retirement
        auto_eoi = 1'b1;
        for (int v = 0; v < NV; v++) begin
            cpu16_mode = VTAB[v][12];
            interval8  = VTAB[v][11];
            raise(int'(VTAB[v][10:8]));
            chk("R1 int raised", {7'd0, int_out}, 8'h01);
            drop_all();
            run_seq(1'b0);
            if (!cpu16_mode) begin
                chk("R3 opcode oe", {7'd0, po[0]}, 8'h01);
                chk("R3 opcode", pd[0], 8'hCD);
                chk(interval8 ? "R5 low byte" : "R4 low byte", pd[1], VTAB[v][7:0]);
                chk("R6 high byte", pd[2], 8'h3C);
            end else begin
                chk("R7 first pulse undriven", {7'd0, po[0]}, 8'h00);
                chk("R7 pointer", pd[1], VTAB[v][7:0]);
            end
            chk("R8 request consumed", {7'd0, int_out}, 8'h00);
            chk("R13 idle oe", {7'd0, data_oe}, 8'h00);
        end

        // strobe retirement and lower-priority blocking
        auto_eoi = 1'b0; cpu16_mode = 1'b0; interval8 = 1'b0;
        raise(3); drop_all(); run_seq(1'b0);
        raise(5);
        chk("R2 lower blocked", {7'd0, int_out}, 8'h00);
        drop_all();
        eoi_pulse();
        chk("R10 strobe releases", {7'd0, int_out}, 8'h01);
        auto_eoi = 1'b1; cpu16_mode = 1'b1;
        run_seq(1'b0);
        raise(6);
        chk("R9 auto retire in word mode", {7'd0, int_out}, 8'h01);
        drop_all(); run_seq(1'b0);

        // strobe coincident with first-pulse selection
        auto_eoi = 1'b0; cpu16_mode = 1'b0;
        raise(5); drop_all(); run_seq(1'b0);
        raise(2);
        chk("R1 higher nested", {7'd0, int_out}, 8'h01);
        drop_all();
        run_seq(1'b1);
        chk("R4 nested level 2", pd[1], 8'hA8);
        raise(6);
        chk("R10 new level in service", {7'd0, int_out}, 8'h00);
        drop_all();
        eoi_pulse();
        chk("R10 coincident strobe hit old level", {7'd0, int_out}, 8'h01);
        auto_eoi = 1'b1; run_seq(1'b0);

        // higher request during a sequence
        auto_eoi = 1'b0;
        raise(5); drop_all();
        ack_pulse(0, 1'b0);
        ack_pulse(1, 1'b0);
        raise(1);
        chk("R12 int held in sequence", {7'd0, int_out}, 8'h01);
        drop_all();
        ack_pulse(2, 1'b0);
        chk("R12 gap after last pulse", {7'd0, p_int}, 8'h00);
        @(negedge clk);
        chk("R12 reassert", {7'd0, int_out}, 8'h01);
        repeat (2) @(negedge clk);
        auto_eoi = 1'b1; run_seq(1'b0);
        eoi_pulse();
        chk("R10 all retired", {7'd0, int_out}, 8'h00);

        // spurious acknowledge
        auto_eoi = 1'b0;
        run_seq(1'b0);
        chk("R11 opcode", pd[0], 8'hCD);
        chk("R11 level 7 low byte", pd[1], 8'hBC);
        chk("R11 high byte", pd[2], 8'h3C);
        raise(7);
        chk("R11 no level in service", {7'd0, int_out}, 8'h01);
        drop_all();
        auto_eoi = 1'b1; run_seq(1'b0);
        chk("R13 final idle", {7'd0, data_oe}, 8'h00);

        finish_run();
    end
endmodule